// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block watches the command stream going to a multi-bank SDRAM, one decoded command per clock. It checks each command against the device's minimum spacing rules. Each nanosecond limit becomes a cycle count, ceil(limit / CLK_NS), where CLK_NS is the clock period given as a parameter. The block keeps one saturating "cycles since" counter per bank for row opens and closes, and global counters for refresh and mode-register writes. When a command comes too early, the bit in an eight-bit violation vector that names the broken rule is set. Each rule has its own bit, and several bits can be set in the same cycle.

The block also predicts two things on the data side. It marks the cycle in which read data arrives for the configured CAS latency. It also tracks the data-mask state, which takes effect on write data in the same cycle as the mask command but on read data two cycles later. The monitor drives nothing on the memory bus. It is meant to sit beside a controller in simulation or on silicon as a protocol checker.

Top module: `sdram_cmd_checker`

## Requirements
- R1: Command codes on `cmd_i`: 0 idle, 1 open row, 2 read, 3 read+auto-close, 4 write, 5 write+auto-close, 6 close bank, 7 close all, 8 mode write, 9 refresh, 10 self-refresh, 11 unmask DQ, 12 mask DQ. After reset, `viol_o`, `rd_data_o`, `rd_mask_o` and `wr_mask_o` are 0, and no earlier command counts as recent. `viol_o` reflects the command of the previous cycle.
- R2: Bit 0 is set when a read or write (codes 2–5) reaches a bank fewer than ceil(20/CLK_NS) cycles after that bank was opened.
- R3: Bit 1 is set when a close (code 6 for the selected bank, code 7 for any bank) or an auto-close read or write comes fewer than ceil(48/CLK_NS) cycles after the bank was opened.
- R4: Bit 2 is set when an open row on a bank comes fewer than ceil(20/CLK_NS) cycles after that bank was closed. It is also set when a mode write, refresh or self-refresh comes that soon after any close.
- R5: Bit 3 is set when a row-class command (codes 1, 8, 9, 10) comes fewer than ceil(68/CLK_NS) cycles after a refresh or self-refresh. It is also set when an open row follows an open of the same bank that closely, or when a mode write, refresh or self-refresh follows an open of any bank that closely.
- R6: Bit 4 is set when an open row comes fewer than ceil(16/CLK_NS) cycles after an open of a different bank.
- R7: Bit 5 is set when a row-class command comes fewer than ceil(16/CLK_NS) cycles after a mode write.
- R8: Bit 6 is set when a row-class command comes too soon after an auto-close. After a read+auto-close at cycle t, the earliest legal cycle is t + BURST − 1 + max(tRP_cycles + 1, CL). After a write+auto-close, it is t + BURST + tRP_cycles.
- R9: Bit 7 is set for any command other than idle when the CAS latency is not supported at the clock period: CL 2 needs CLK_NS ≥ 10, CL 3 needs CLK_NS ≥ 8, and any other CL value is never supported.
- R10: A read (code 2 or 3) at cycle t sets `rd_data_o` high in cycle t + CL only. CL is held constant while reads are in flight.
- R11: A mask command at cycle t sets `wr_mask_o` in cycle t+1 and `rd_mask_o` in cycle t+2. An unmask command clears each output with the same delays. Both flags hold between the two commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 4 | Decoded command code for this cycle |
| bank_i | input | BANK_W (1) | Bank addressed by the command |
| cas_lat_i | input | 2 | Configured CAS latency (2 or 3) |
| viol_o | output | 8 | Per-rule violation flags for the previous cycle's command |
| rd_data_o | output | 1 | Read data expected on DQ this cycle |
| rd_mask_o | output | 1 | Read data in this cycle is masked |
| wr_mask_o | output | 1 | Write data of the previous cycle was masked |

## Verification
On every cycle, the assertions check the following. Each violation bit traces back to a command of the right class. An auto-close always opens a non-zero waiting window. The cycle counters stay saturated until a new event arrives. Read-data and mask rises line up with a read or mask command the right number of cycles earlier. Only the directed scenarios can show that each limit is exact: a command one cycle early sets exactly its own bit, and the same command at the limit sets none. They also show the latency dependence of the read prediction.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [3:0] {
    CMD_IDLE   = 4'd0,
    CMD_ACT    = 4'd1,
    CMD_RD     = 4'd2,
    CMD_RDA    = 4'd3,
    CMD_WR     = 4'd4,
    CMD_WRA    = 4'd5,
    CMD_PRE    = 4'd6,
    CMD_PREALL = 4'd7,
    CMD_MODE   = 4'd8,
    CMD_REF    = 4'd9,
    CMD_SREF   = 4'd10,
    CMD_DQEN   = 4'd11,
    CMD_DQMASK = 4'd12
  } cmd_e;

  localparam int NUM_RULES = 8;
  localparam int V_RCD = 0;
  localparam int V_RAS = 1;
  localparam int V_RP  = 2;
  localparam int V_RC  = 3;
  localparam int V_RRD = 4;
  localparam int V_MRD = 5;
  localparam int V_APR = 6;
  localparam int V_CLK = 7;
endpackage

// File: rtl/sdc_since_cnt.sv
module sdc_since_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= SAT;
    else if (hit)        cnt <= W'(1);
    else if (cnt != SAT) cnt <= cnt + W'(1);
  end

  // R1: with no new event, a saturated counter keeps meaning "long ago"
  assert_cnt_saturate_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt == SAT && !hit) |=> (cnt == SAT));
endmodule

// File: rtl/sdc_dq_predict.sv
module sdc_dq_predict #(
  parameter int MAX_CL = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_hit,
  input  logic       mask_hit,
  input  logic       en_hit,
  input  logic [1:0] cas_lat,
  output logic       rd_data_o,
  output logic       rd_mask_o,
  output logic       wr_mask_o
);
  localparam int TW = (MAX_CL > 2) ? $clog2(MAX_CL) : 1;

  logic [MAX_CL-1:0] rd_sr;
  logic [TW-1:0]     tap;

  always_comb begin
    if (cas_lat == 2'd0)             tap = '0;
    else if (int'(cas_lat) > MAX_CL) tap = TW'(MAX_CL - 1);
    else                             tap = TW'(cas_lat - 2'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sr     <= '0;
      wr_mask_o <= 1'b0;
      rd_mask_o <= 1'b0;
    end else begin
      rd_sr <= {rd_sr[MAX_CL-2:0], rd_hit};
      if (mask_hit)    wr_mask_o <= 1'b1;
      else if (en_hit) wr_mask_o <= 1'b0;
      rd_mask_o <= wr_mask_o;
    end
  end

  assign rd_data_o = rd_sr[tap];

  assert_rd_lat3_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o && cas_lat == 2'd3) |-> $past(rd_hit, 3));
  assert_rd_lat2_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o && cas_lat == 2'd2) |-> $past(rd_hit, 2));
  assert_wr_mask_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_mask_o) |-> $past(mask_hit));
  assert_rd_mask_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_mask_o) |-> $past(mask_hit, 2));
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdc_pkg::*;
#(
  parameter int CLK_NS     = 8,
  parameter int NUM_BANKS  = 2,
  parameter int BURST      = 2,
  parameter int MAX_CL     = 3,
  parameter int RCD_NS     = 20,
  parameter int RP_NS      = 20,
  parameter int RAS_NS     = 48,
  parameter int RC_NS      = 68,
  parameter int RRD_NS     = 16,
  parameter int MRD_NS     = 16,
  parameter int CL2_MIN_NS = 10,
  parameter int CL3_MIN_NS = 8,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [1:0]           cas_lat_i,
  output logic [NUM_RULES-1:0] viol_o,
  output logic                 rd_data_o,
  output logic                 rd_mask_o,
  output logic                 wr_mask_o
);
  localparam int T_RCD = (RCD_NS + CLK_NS - 1) / CLK_NS;
  localparam int T_RP  = (RP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int T_RAS = (RAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int T_RC  = (RC_NS  + CLK_NS - 1) / CLK_NS;
  localparam int T_RRD = (RRD_NS + CLK_NS - 1) / CLK_NS;
  localparam int T_MRD = (MRD_NS + CLK_NS - 1) / CLK_NS;
  localparam int T_MAX = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int CW    = $clog2(T_MAX + 1) + 1;
  localparam int WW    = $clog2(BURST + T_RP + MAX_CL + 2) + 1;

  localparam logic [CW-1:0] L_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] L_MRD = CW'(T_MRD);

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic is_col, is_auto, is_row, is_cfg;
  assign is_col  = (cmd == CMD_RD) || (cmd == CMD_RDA) || (cmd == CMD_WR) || (cmd == CMD_WRA);
  assign is_auto = (cmd == CMD_RDA) || (cmd == CMD_WRA);
  assign is_cfg  = (cmd == CMD_MODE) || (cmd == CMD_REF) || (cmd == CMD_SREF);
  assign is_row  = (cmd == CMD_ACT) || is_cfg;

  // per-bank history
  logic [CW-1:0]        act_cnt [NUM_BANKS];
  logic [CW-1:0]        pre_cnt [NUM_BANKS];
  logic [NUM_BANKS-1:0] act_hit, pre_hit, bank_oh;
  logic [NUM_BANKS-1:0] rcd_short, ras_short, rc_short, rrd_short, rp_short;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_oh[b] = (bank_i == BANK_W'(b));
    assign act_hit[b] = (cmd == CMD_ACT) && bank_oh[b];
    assign pre_hit[b] = ((cmd == CMD_PRE) && bank_oh[b]) || (cmd == CMD_PREALL);

    sdc_since_cnt #(.W(CW)) u_act (.clk(clk), .rst(rst), .hit(act_hit[b]), .cnt(act_cnt[b]));
    sdc_since_cnt #(.W(CW)) u_pre (.clk(clk), .rst(rst), .hit(pre_hit[b]), .cnt(pre_cnt[b]));

    assign rcd_short[b] = act_cnt[b] < L_RCD;
    assign ras_short[b] = act_cnt[b] < L_RAS;
    assign rc_short[b]  = act_cnt[b] < L_RC;
    assign rrd_short[b] = act_cnt[b] < L_RRD;
    assign rp_short[b]  = pre_cnt[b] < L_RP;
  end

  // global history
  logic [CW-1:0] ref_cnt, mrs_cnt;
  logic          ref_hit, mrs_hit;
  assign ref_hit = (cmd == CMD_REF) || (cmd == CMD_SREF);
  assign mrs_hit = (cmd == CMD_MODE);

  sdc_since_cnt #(.W(CW)) u_ref (.clk(clk), .rst(rst), .hit(ref_hit), .cnt(ref_cnt));
  sdc_since_cnt #(.W(CW)) u_mrs (.clk(clk), .rst(rst), .hit(mrs_hit), .cnt(mrs_cnt));

  // auto-close waiting window, counted down to zero
  logic [WW-1:0] wait_q, wait_load, wait_dec;
  int            rda_len;

  always_comb begin
    rda_len = BURST - 1 + (((T_RP + 1) > int'(cas_lat_i)) ? (T_RP + 1) : int'(cas_lat_i));
    if (cmd == CMD_RDA)      wait_load = WW'(rda_len - 1);
    else if (cmd == CMD_WRA) wait_load = WW'(BURST + T_RP - 1);
    else                     wait_load = '0;
    wait_dec = (wait_q == '0) ? '0 : wait_q - WW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) wait_q <= '0;
    else     wait_q <= (wait_load > wait_dec) ? wait_load : wait_dec;
  end

  // rule evaluation
  logic                 cl_ok;
  logic [NUM_RULES-1:0] viol_d;

  always_comb begin
    cl_ok = ((cas_lat_i == 2'd2) && (CLK_NS >= CL2_MIN_NS)) ||
            ((cas_lat_i == 2'd3) && (CLK_NS >= CL3_MIN_NS));
    viol_d        = '0;
    viol_d[V_RCD] = is_col && |(rcd_short & bank_oh);
    viol_d[V_RAS] = (((cmd == CMD_PRE) || is_auto) && |(ras_short & bank_oh)) ||
                    ((cmd == CMD_PREALL) && |ras_short);
    viol_d[V_RP]  = ((cmd == CMD_ACT) && |(rp_short & bank_oh)) || (is_cfg && |rp_short);
    viol_d[V_RC]  = (is_row && (ref_cnt < L_RC)) ||
                    ((cmd == CMD_ACT) && |(rc_short & bank_oh)) ||
                    (is_cfg && |rc_short);
    viol_d[V_RRD] = (cmd == CMD_ACT) && |(rrd_short & ~bank_oh);
    viol_d[V_MRD] = is_row && (mrs_cnt < L_MRD);
    viol_d[V_APR] = is_row && (wait_q != '0);
    viol_d[V_CLK] = (cmd != CMD_IDLE) && !cl_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) viol_o <= '0;
    else     viol_o <= viol_d;
  end

  sdc_dq_predict #(.MAX_CL(MAX_CL)) u_dq (
    .clk      (clk),
    .rst      (rst),
    .rd_hit   ((cmd == CMD_RD) || (cmd == CMD_RDA)),
    .mask_hit (cmd == CMD_DQMASK),
    .en_hit   (cmd == CMD_DQEN),
    .cas_lat  (cas_lat_i),
    .rd_data_o(rd_data_o),
    .rd_mask_o(rd_mask_o),
    .wr_mask_o(wr_mask_o)
  );

  assert_rcd_cause_R2: assert property (@(posedge clk) disable iff (rst)
    viol_o[V_RCD] |-> $past(is_col));
  assert_rrd_cause_R6: assert property (@(posedge clk) disable iff (rst)
    viol_o[V_RRD] |-> $past(cmd == CMD_ACT));
  assert_mrd_cause_R7: assert property (@(posedge clk) disable iff (rst)
    viol_o[V_MRD] |-> $past(is_row));
  assert_apr_window_R8: assert property (@(posedge clk) disable iff (rst)
    is_auto |=> (wait_q != '0));
  assert_clk_cause_R9: assert property (@(posedge clk) disable iff (rst)
    viol_o[V_CLK] |-> $past(cmd != CMD_IDLE));
endmodule

// File: tb/test_sdram_cmd_checker.sv
module test_sdram_cmd_checker;
  import sdc_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cmd = 4'd0;
  logic [0:0] bank = 1'b0;
  logic [1:0] cas = 2'd3;
  logic [7:0] viol;
  logic       rd_data, rd_mask, wr_mask;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  sdram_cmd_checker #(.CLK_NS(8), .NUM_BANKS(2), .BURST(2)) i_sdram_cmd_checker (
    .clk(clk), .rst(rst), .cmd_i(cmd), .bank_i(bank), .cas_lat_i(cas),
    .viol_o(viol), .rd_data_o(rd_data), .rd_mask_o(rd_mask), .wr_mask_o(wr_mask)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd = CMD_IDLE; cas = 2'd3; bank = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(input cmd_e c, input logic b);
    cmd = c; bank = b;
    @(negedge clk);
    cmd = CMD_IDLE;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "viol after reset", viol, 0);
    chk("R1", "rd_data after reset", rd_data, 0);
    chk("R1", "masks after reset", {rd_mask, wr_mask}, 0);
  endtask

  task automatic t_rcd();
    do_reset(); issue(CMD_ACT, 0); idle(1); issue(CMD_RD, 0);
    chk("R2", "read 2 cycles after open", viol, 8'h01);
    do_reset(); issue(CMD_ACT, 0); idle(2); issue(CMD_WR, 0);
    chk("R2", "write 3 cycles after open", viol, 8'h00);
  endtask

  task automatic t_ras();
    do_reset(); issue(CMD_ACT, 0); idle(4); issue(CMD_PRE, 0);
    chk("R3", "close 5 cycles after open", viol, 8'h02);
    do_reset(); issue(CMD_ACT, 0); idle(5); issue(CMD_PRE, 0);
    chk("R3", "close 6 cycles after open", viol, 8'h00);
    do_reset(); issue(CMD_ACT, 1); idle(4); issue(CMD_RDA, 1);
    chk("R3", "auto-close read 5 cycles after open", viol, 8'h02);
    do_reset(); issue(CMD_ACT, 1); idle(4); issue(CMD_PREALL, 0);
    chk("R3", "close-all 5 cycles after open", viol, 8'h02);
  endtask

  task automatic t_rp();
    do_reset(); issue(CMD_ACT, 0); idle(6); issue(CMD_PRE, 0);
    chk("R4", "close at 7", viol, 8'h00);
    idle(1); issue(CMD_ACT, 0);
    chk("R4", "reopen 2 after close", viol, 8'h04);
    do_reset(); issue(CMD_ACT, 0); idle(5); issue(CMD_PRE, 0); idle(2); issue(CMD_ACT, 0);
    chk("R4", "reopen 3 after close", viol, 8'h00);
  endtask

  task automatic t_rc();
    do_reset(); issue(CMD_REF, 0); idle(7); issue(CMD_REF, 0);
    chk("R5", "refresh 8 after refresh", viol, 8'h08);
    do_reset(); issue(CMD_REF, 0); idle(8); issue(CMD_REF, 0);
    chk("R5", "refresh 9 after refresh", viol, 8'h00);
  endtask

  task automatic t_rrd();
    do_reset(); issue(CMD_ACT, 0); issue(CMD_ACT, 1);
    chk("R6", "open other bank 1 cycle later", viol, 8'h10);
    do_reset(); issue(CMD_ACT, 0); idle(1); issue(CMD_ACT, 1);
    chk("R6", "open other bank 2 cycles later", viol, 8'h00);
  endtask

  task automatic t_mrd();
    do_reset(); issue(CMD_MODE, 0); issue(CMD_REF, 0);
    chk("R7", "refresh 1 after mode write", viol, 8'h20);
    do_reset(); issue(CMD_MODE, 0); idle(1); issue(CMD_REF, 0);
    chk("R7", "refresh 2 after mode write", viol, 8'h00);
  endtask

  task automatic t_apr();
    do_reset(); issue(CMD_ACT, 0); idle(5); issue(CMD_RDA, 0); idle(3); issue(CMD_REF, 0);
    chk("R8", "refresh 4 after read+close", viol, 8'h40);
    do_reset(); issue(CMD_ACT, 0); idle(5); issue(CMD_RDA, 0); idle(4); issue(CMD_REF, 0);
    chk("R8", "refresh 5 after read+close", viol, 8'h00);
    do_reset(); issue(CMD_ACT, 1); idle(5); issue(CMD_WRA, 1); idle(3); issue(CMD_ACT, 1);
    chk("R8", "reopen 4 after write+close", viol, 8'h40);
    do_reset(); issue(CMD_ACT, 1); idle(5); issue(CMD_WRA, 1); idle(4); issue(CMD_ACT, 1);
    chk("R8", "reopen 5 after write+close", viol, 8'h00);
  endtask

  task automatic t_clk();
    do_reset(); cas = 2'd2; issue(CMD_REF, 0);
    chk("R9", "CL2 at 8 ns period", viol, 8'h80);
    idle(1);
    chk("R9", "idle never flags clock rule", viol, 8'h00);
    cas = 2'd3;
  endtask

  task automatic t_rd(input logic [1:0] cl);
    do_reset(); cas = cl; issue(CMD_RD, 0);
    for (int k = 1; k <= 4; k++) begin
      chk("R10", $sformatf("rd_data CL%0d k=%0d", cl, k), rd_data, (k == int'(cl)));
      @(negedge clk);
    end
    cas = 2'd3;
  endtask

  task automatic t_mask();
    do_reset(); issue(CMD_DQMASK, 0);
    chk("R11", "write mask 1 after mask", wr_mask, 1);
    chk("R11", "read mask not yet", rd_mask, 0);
    idle(1);
    chk("R11", "read mask 2 after mask", rd_mask, 1);
    issue(CMD_DQEN, 0);
    chk("R11", "write mask cleared", wr_mask, 0);
    chk("R11", "read mask still held", rd_mask, 1);
    idle(1);
    chk("R11", "read mask cleared", rd_mask, 0);
  endtask

  initial begin
    t_reset(); t_rcd(); t_ras(); t_rp(); t_rc(); t_rrd(); t_mrd();
    t_apr(); t_clk(); t_rd(2'd3); t_rd(2'd2); t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule